// File: doc/BRIEF.md
# Byte-Wide Configuration Port Receiver

This block is the device-side receiver of a byte-parallel configuration port. A host drives an 8-bit data bus, an active-low select and an active-low write strobe. The receiver samples the bus on rising edges of the configuration clock and answers with a BUSY handshake. It first hunts for a 32-bit synchronisation pattern. Once that pattern has arrived, it packs each group of four bytes into a 32-bit word for the internal configuration bus and flags each word with a one-cycle valid pulse.

The host may pause at any point by raising select, and it may spread a packet over as many separate write bursts as it likes. If the write strobe is raised while select is still low, the receiver treats the load as aborted. It then discards any partial word, holds BUSY for a fixed recovery time and drops word alignment. No further words are produced until a fresh synchronisation pattern has been received.

After every completed word, BUSY is forced high for a configurable number of cycles to model internal back-pressure. A value of zero means BUSY is never raised except during abort recovery. In that case the host may present one byte on every clock.

Top module: `cfg_byte_port`

## Requirements
- R1: A byte on `din` is taken only on a rising `cfg_clk` edge where `sel_n` is 0, `wstb_n` is 0 and `busy` is 0. A byte held on the bus while `busy` is 1 is taken exactly once, on the first edge where `busy` is 0.
- R2: While `sel_n` is 1, clock edges have no effect whatever `wstb_n` and `din` do. No byte is taken, no abort is raised and no word is produced.
- R3: The byte position inside the word being assembled is kept across any pause with `sel_n` at 1. A word split over several bursts equals the word sent in one burst.
- R4: Before alignment, each taken byte enters a 32-bit window, and the earliest byte ends up as the most significant. The window is compared with 32'hAA995566 after every byte, so a match is found even when other bytes precede the pattern. Neither hunted bytes nor the pattern itself produce a word.
- R5: Once aligned, every four taken bytes form one word, the first byte in bits 31:24 and the last in bits 7:0. `cfg_word` carries the word and `cfg_word_vld` is 1 for exactly the cycle after the edge that took the fourth byte. While aligned, the value 32'hAA995566 is ordinary data.
- R6: After the edge that completes a word, `busy` is 1 for exactly `GAP_CYCLES` cycles (default 2). With `GAP_CYCLES` = 0 a completed word never raises `busy`.
- R7: A rising edge with `sel_n` at 0 and `wstb_n` at 1 is an abort. `abort_seen` is 1 in the cycle after that edge, and any partly assembled word is discarded.
- R8: After the last abort edge, `busy` is 1 for exactly `ABORT_CYCLES` cycles (default 4).
- R9: After an abort, alignment is lost. Taken bytes produce no word until the pattern 32'hAA995566 has been received again, and words then restart at byte position 0.
- R10: While `rst_n` is 0 at a rising edge, alignment, the byte position and `busy` are cleared. `cfg_word_vld` and `abort_seen` are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low port select from the host |
| wstb_n | input | 1 | Active-low write strobe from the host |
| din | input | 8 | Configuration data byte |
| busy | output | 1 | Handshake: 1 means the port takes no byte this edge |
| cfg_word | output | 32 | Last assembled configuration word |
| cfg_word_vld | output | 1 | One-cycle pulse marking a new `cfg_word` |
| abort_seen | output | 1 | One-cycle pulse after an abort edge |

## Verification
The bench places junk bytes ahead of the pattern, uses a leading repeated 0xAA and sends the pattern again as data once aligned. A window that is reset on a mismatch would miss the sync, and a hunter left running would realign in the middle of the data. It pauses in the middle of words while toggling the strobe with select high. A design that counts those edges or takes them for an abort would produce shifted words or false abort pulses. Words are driven back to back, and the BUSY length is counted after words and after aborts. An off-by-one timer, or a byte taken twice while BUSY is high, shows up as a wrong count or a corrupted word. After an abort it sends plain data before a new sync. Any word that appears there shows that the partial word or the alignment survived the abort.

// File: rtl/cfgp_pkg.sv
// Package cfgp_pkg: shared constants and types for the configuration port.
// Assumes a byte-wide host bus and 32-bit configuration words.
package cfgp_pkg;
    localparam int          BYTE_W    = 8;
    localparam int          WORD_B    = 4;
    localparam int          WORD_W    = BYTE_W * WORD_B;
    localparam logic [31:0] SYNC_WORD = 32'hAA995566;

    typedef enum logic {
        ST_HUNT    = 1'b0,
        ST_ALIGNED = 1'b1
    } align_t;
endpackage

// File: rtl/cfgp_busy_ctrl.sv
// Module cfgp_busy_ctrl: down-counter that drives the BUSY handshake.
// A completed word loads GAP_CYCLES (when non-zero) and an abort loads
// ABORT_CYCLES. BUSY is high while the count is non-zero. An abort wins
// over a completed word. Assumes both loads fit the derived counter width.
module cfgp_busy_ctrl #(
    parameter int GAP_CYCLES   = 2,
    parameter int ABORT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_done,
    input  logic abort_hit,
    output logic busy
);
    localparam int MAXC = (GAP_CYCLES > ABORT_CYCLES) ? GAP_CYCLES : ABORT_CYCLES;
    localparam int CW   = (MAXC < 1) ? 1 : $clog2(MAXC + 1);
    localparam logic [CW-1:0] GAP_LD   = CW'(GAP_CYCLES);
    localparam logic [CW-1:0] ABORT_LD = CW'(ABORT_CYCLES);

    logic [CW-1:0] cnt;

    // Load or count down the hold-off timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (abort_hit) begin
            cnt <= ABORT_LD;
        end else if (word_done && (GAP_CYCLES != 0)) begin
            cnt <= GAP_LD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // BUSY follows a non-zero timer.
    assign busy = (cnt != '0);
endmodule

// File: rtl/cfgp_sync_hunt.sv
// Module cfgp_sync_hunt: tracks word alignment. While hunting, each taken
// byte shifts into a window whose oldest byte is the most significant. The
// window is compared against SYNC after every byte. An abort drops
// alignment and clears the window. Assumes `take` only when a byte is valid.
module cfgp_sync_hunt #(
    parameter int          BW   = 8,
    parameter int          WW   = 32,
    parameter logic [WW-1:0] SYNC = 32'hAA995566
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          abort_hit,
    input  logic [BW-1:0] din,
    output logic          aligned
);
    import cfgp_pkg::*;

    align_t          state;
    logic [WW-1:0]   window;
    logic [WW-1:0]   window_nx;

    // Window contents after shifting in the current byte.
    assign window_nx = {window[WW-BW-1:0], din};

    // Hunt for the pattern and hold alignment until abort or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_hit) begin
            state  <= ST_HUNT;
            window <= '0;
        end else if (take && state == ST_HUNT) begin
            window <= window_nx;
            if (window_nx == SYNC) begin
                state <= ST_ALIGNED;
            end
        end
    end

    assign aligned = (state == ST_ALIGNED);
endmodule

// File: rtl/cfgp_word_pack.sv
// Module cfgp_word_pack: packs NB bytes, first byte most significant, into
// one word, and pulses word_vld in the cycle after the last byte. word_done
// flags, combinationally, the edge that completes a word. An abort discards
// the partial word. Assumes `take` only while aligned.
module cfgp_word_pack #(
    parameter int BW = 8,
    parameter int NB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             abort_hit,
    input  logic [BW-1:0]    din,
    output logic [BW*NB-1:0] word,
    output logic             word_vld,
    output logic             word_done
);
    localparam int PW = (NB < 2) ? 1 : $clog2(NB);
    localparam logic [PW-1:0] LAST = PW'(NB - 1);

    logic [PW-1:0]      pos;
    logic [BW*NB-1:0]   acc;

    // Marks the edge that takes the final byte of a word.
    assign word_done = take && (pos == LAST);

    // Byte position and partial-word accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_hit) begin
            pos <= '0;
            acc <= '0;
        end else if (take) begin
            acc <= {acc[BW*(NB-1)-1:0], din};
            pos <= word_done ? '0 : pos + 1'b1;
        end
    end

    // Publish the finished word with a one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= word_done && !abort_hit;
            if (word_done && !abort_hit) begin
                word <= {acc[BW*(NB-1)-1:0], din};
            end
        end
    end
endmodule

// File: rtl/cfg_byte_port.sv
// Module cfg_byte_port: top of the byte-wide configuration receiver.
// Decodes take and abort edges from the host strobes, hunts for the sync
// word, packs aligned bytes into words and drives BUSY. Assumes the host
// strobes are synchronous to cfg_clk.
module cfg_byte_port #(
    parameter int          GAP_CYCLES   = 2,
    parameter int          ABORT_CYCLES = 4,
    parameter logic [31:0] SYNC_PATTERN = cfgp_pkg::SYNC_WORD
) (
    input  logic        cfg_clk,
    input  logic        rst_n,
    input  logic        sel_n,
    input  logic        wstb_n,
    input  logic [7:0]  din,
    output logic        busy,
    output logic [31:0] cfg_word,
    output logic        cfg_word_vld,
    output logic        abort_seen
);
    import cfgp_pkg::*;

    logic take_byte;
    logic abort_hit;
    logic aligned;
    logic word_done;

    // Host strobe decode for this edge.
    assign take_byte = !sel_n && !wstb_n && !busy;
    assign abort_hit = !sel_n && wstb_n;

    // Register the abort indication as a one-cycle pulse.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n) abort_seen <= 1'b0;
        else        abort_seen <= abort_hit;
    end

    cfgp_sync_hunt #(
        .BW   (BYTE_W),
        .WW   (WORD_W),
        .SYNC (SYNC_PATTERN)
    ) u_hunt (
        .clk       (cfg_clk),
        .rst_n     (rst_n),
        .take      (take_byte),
        .abort_hit (abort_hit),
        .din       (din),
        .aligned   (aligned)
    );

    cfgp_word_pack #(
        .BW (BYTE_W),
        .NB (WORD_B)
    ) u_pack (
        .clk       (cfg_clk),
        .rst_n     (rst_n),
        .take      (take_byte && aligned),
        .abort_hit (abort_hit),
        .din       (din),
        .word      (cfg_word),
        .word_vld  (cfg_word_vld),
        .word_done (word_done)
    );

    cfgp_busy_ctrl #(
        .GAP_CYCLES   (GAP_CYCLES),
        .ABORT_CYCLES (ABORT_CYCLES)
    ) u_busy (
        .clk       (cfg_clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .abort_hit (abort_hit),
        .busy      (busy)
    );
endmodule

// File: rtl/cfgp_checker.sv
// Module cfgp_checker: temporal properties of cfg_byte_port, attached by bind.
module cfgp_checker #(
    parameter int GAP_CYCLES = 2
) (
    input logic cfg_clk,
    input logic rst_n,
    input logic sel_n,
    input logic wstb_n,
    input logic busy,
    input logic cfg_word_vld,
    input logic abort_seen,
    input logic aligned
);
    assert_idle_ignored_R2: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        sel_n |=> (!cfg_word_vld && !abort_seen));

    assert_vld_pulse_R5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_word_vld |=> !cfg_word_vld);

    assert_word_only_aligned_R5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_word_vld |-> aligned);

    assert_gap_busy_R6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_word_vld |-> (busy || GAP_CYCLES == 0));

    assert_abort_pulse_R7: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (!sel_n && wstb_n) |=> abort_seen);

    assert_abort_busy_R8: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        abort_seen |-> busy);

    assert_abort_unaligned_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        abort_seen |-> !aligned);

    assert_reset_clear_R10: assert property (@(posedge cfg_clk)
        !rst_n |=> (!busy && !cfg_word_vld && !abort_seen && !aligned));
endmodule

bind cfg_byte_port cfgp_checker #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .cfg_clk      (cfg_clk),
    .rst_n        (rst_n),
    .sel_n        (sel_n),
    .wstb_n       (wstb_n),
    .busy         (busy),
    .cfg_word_vld (cfg_word_vld),
    .abort_seen   (abort_seen),
    .aligned      (aligned)
);

// File: tb/cfg_byte_port_test.sv
// Scoreboard bench for cfg_byte_port: the driver pushes expected words, and
// a monitor pops and compares them on each valid pulse.
module cfg_byte_port_test;
    localparam int GAP = 2;
    localparam int ABT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        wstb_n = 1'b1;
    logic [7:0]  din = 8'h00;
    logic        busy;
    logic [31:0] cfg_word;
    logic        cfg_word_vld;
    logic        abort_seen;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    bit          m_aligned = 1'b0;
    logic [31:0] m_win = '0;
    logic [31:0] m_acc = '0;
    int          m_pos = 0;

    always #10 clk = ~clk;

    cfg_byte_port #(.GAP_CYCLES(GAP), .ABORT_CYCLES(ABT)) uut (
        .cfg_clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n), .din(din),
        .busy(busy), .cfg_word(cfg_word), .cfg_word_vld(cfg_word_vld),
        .abort_seen(abort_seen)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each produced word against the scoreboard (R5, R3, R9).
    always @(negedge clk) begin
        if (rst_n && cfg_word_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected word", cfg_word, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(cfg_word == e, "R5", "word value", cfg_word, e);
            end
        end
    end

    // Driver: present one byte, wait out BUSY, update the expected model (R1, R4).
    task automatic send_byte(input logic [7:0] b);
        sel_n = 1'b0; wstb_n = 1'b0; din = b;
        while (busy) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        if (!m_aligned) begin
            m_win = {m_win[23:0], b};
            if (m_win == 32'hAA995566) begin
                m_aligned = 1'b1;
                m_pos = 0;
            end
        end else begin
            m_acc = {m_acc[23:0], b};
            m_pos++;
            if (m_pos == 4) begin
                exp_q.push_back(m_acc);
                m_pos = 0;
            end
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8]);
    endtask

    // Pause with select high while the strobe and data wiggle (R2).
    task automatic pause(input int n);
        for (int i = 0; i < n; i++) begin
            sel_n = 1'b1; wstb_n = i[0]; din = 8'(i * 37);
            @(negedge clk);
            check(!abort_seen && !cfg_word_vld && !busy, "R2", "idle activity",
                  {29'b0, abort_seen, cfg_word_vld, busy}, 32'h0);
        end
    endtask

    // Count the busy cycles seen from now on, with the host idle.
    task automatic busy_run(input int exp, input string req);
        int n = 0;
        sel_n = 1'b1; wstb_n = 1'b1;
        while (busy && n < 20) begin n++; @(negedge clk); end
        check(n == exp, req, "busy length", n, exp);
    endtask

    task automatic do_abort();
        sel_n = 1'b0; wstb_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(abort_seen == 1'b1, "R7", "abort pulse", abort_seen, 1);
        m_aligned = 1'b0; m_win = '0; m_pos = 0;
        busy_run(ABT, "R8");
        check(abort_seen == 1'b0, "R7", "abort pulse ends", abort_seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !cfg_word_vld && !abort_seen, "R10", "reset outputs",
              {29'b0, busy, cfg_word_vld, abort_seen}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: junk ahead of the pattern, then the pattern, then data.
        send_byte(8'h11); send_byte(8'h22);
        send_word(32'hAA995566);
        check(exp_q.size() == 0 && !cfg_word_vld, "R4", "no word from sync", exp_q.size(), 0);
        send_word(32'hDEADBEEF);
        busy_run(GAP, "R6");

        // R3: split word with pauses between bursts.
        send_byte(8'h01); send_byte(8'h23);
        pause(7);
        send_byte(8'h45);
        pause(3);
        send_byte(8'h67);
        busy_run(GAP, "R6");

        // R5: the pattern is plain data once aligned; back-to-back words (R1).
        send_word(32'hAA995566);
        send_word(32'h0BADF00D);
        send_word(32'hCAFEF00D);
        busy_run(GAP, "R6");

        // R7: abort mid-word discards the partial word.
        send_byte(8'h99); send_byte(8'h88);
        do_abort();

        // R9: data without a new sync yields nothing.
        send_word(32'h12345678);
        send_word(32'h9ABCDEF0);
        pause(2);
        check(exp_q.size() == 0, "R9", "no words before resync", exp_q.size(), 0);

        // R4: leading repeated 0xAA still finds the pattern.
        send_byte(8'hAA);
        send_word(32'hAA995566);
        send_word(32'h5A5AA5A5);
        busy_run(GAP, "R6");

        // R8: abort taken while BUSY is high reloads the recovery time.
        send_word(32'h00FF00FF);
        do_abort();

        // R10: reset drops alignment.
        send_word(32'hAA995566);
        rst_n = 1'b0; sel_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        m_aligned = 1'b0; m_win = '0; m_pos = 0;
        send_word(32'h11111111);
        pause(2);
        check(exp_q.size() == 0, "R10", "reset clears alignment", exp_q.size(), 0);

        pause(4);
        check(exp_q.size() == 0, "R5", "all expected words seen", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL R1 watchdog expired: actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule